// File: doc/BRIEF.md
# Line-Delay Luma/Chroma Comb Separator

This block splits a sampled composite video stream into a chrominance component and a luminance component. Samples arrive at three times the colour subcarrier rate, qualified by a sample-enable strobe. Each sample is paired with the sample taken one video line earlier. The chroma result is half their difference. The luma result is a latency-matched copy of the incoming sample minus that chroma.

At three times the subcarrier rate a video line spans 682.5 samples. The line delay therefore alternates between 682 and 683 samples. The choice flips on every line-start strobe. The band-pass stages around the comb are modelled as a fixed-latency placeholder, so that the delay matching between the chroma path and the luma compensation path can be checked.

A bypass select routes an external luma and chroma pair straight to the outputs. It takes effect on the next enabled sample, with no wait for any blanking interval. The comb pipeline keeps running while bypass is active.

Top module: `yc_comb_separator`

## Requirements
- R1: After synchronous reset both outputs read 0. They stay 0 while no sample enable arrives, whatever the other inputs do.
- R2: The delayed operand for a sample is the input sample taken D enabled samples earlier. D is 682 (LINE_SHORT) on even lines and 683 on odd lines.
- R3: Reset sets the line parity to even. An enabled line-start strobe flips the parity, and the new parity already applies to the sample that carries the strobe.
- R4: Samples are 10-bit two's complement. Combed chroma is the 11-bit difference (current minus delayed), shifted right arithmetically by one (rounding toward minus infinity), then saturated to 10 bits.
- R5: Combed luma is the latency-matched current sample minus the combed chroma, computed on 11 bits and saturated to 10 bits.
- R6: When bypass is high on an enabled sample, the following clock shows the luma and chroma outputs equal to the external luma and chroma captured with that enable.
- R7: With bypass low, the combed results of the sample taken at enable n appear on the outputs right after enable n+BP_LAT+3 (n+5 with the default BP_LAT of 2).
- R8: All state advances only on enabled samples. Without an enable, the outputs hold their values even if the data, line-start or bypass inputs change.
- R9: Bypass does not disturb the comb pipeline. On the first enable with bypass low after a bypass period, the outputs already carry the combed result from R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock (three times subcarrier) |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | Sample-enable strobe |
| line_start | input | 1 | Line-start strobe, qualified by smp_en |
| bypass | input | 1 | High selects the external pair |
| cvbs_in | input | 10 | Signed composite sample |
| ext_luma | input | 10 | Signed external luma sample |
| ext_chroma | input | 10 | Signed external chroma sample |
| luma_out | output | 10 | Signed luma result, registered |
| chroma_out | output | 10 | Signed chroma result, registered |

## Verification
The assertions assume that line_start counts only together with smp_en, and that reset is held for at least one clock edge before the first sample. The bench raises line_start only on enabled samples. It keeps reset high for several edges, then waits for an idle cycle before the stream starts. The comb checks assume that the delay memory has been filled since reset. The bench therefore compares combed outputs only for samples whose delayed partner was itself written after reset. During idle cycles it changes line_start, bypass and data on purpose, to show that they are ignored.

// File: rtl/yc_comb_pkg.sv
package yc_comb_pkg;
  localparam int SAMPLE_W = 10;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic signed [SAMPLE_W:0]   wide_t;

  // clamp a guard-bit value into the sample range
  function automatic sample_t sat_w(wide_t v);
    if (v[SAMPLE_W] != v[SAMPLE_W-1])
      return v[SAMPLE_W] ? sample_t'({1'b1, {(SAMPLE_W-1){1'b0}}})
                         : sample_t'({1'b0, {(SAMPLE_W-1){1'b1}}});
    return sample_t'(v[SAMPLE_W-1:0]);
  endfunction
endpackage

// File: rtl/yc_line_delay.sv
module yc_line_delay
  import yc_comb_pkg::*;
#(
  parameter int LINE_SHORT = 682
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    smp_en,
  input  logic    line_start,
  input  sample_t din,
  output sample_t cur_q,
  output sample_t dly_q
);
  localparam int LINE_LONG = LINE_SHORT + 1;
  localparam int AW        = $clog2(LINE_LONG + 1);
  localparam int DEPTH     = 1 << AW;

  sample_t         mem [DEPTH];
  logic [AW-1:0]   wr_ptr;
  logic [AW-1:0]   rd_ptr;
  logic            odd_line;
  logic            use_long;

  assign use_long = odd_line ^ line_start;
  assign rd_ptr   = wr_ptr - (use_long ? AW'(LINE_LONG) : AW'(LINE_SHORT));

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      odd_line <= 1'b0;
      cur_q    <= '0;
    end else if (smp_en) begin
      wr_ptr <= wr_ptr + 1'b1;
      cur_q  <= din;
      if (line_start) odd_line <= ~odd_line;
    end
  end

  // storage kept free of reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (smp_en) begin
      mem[wr_ptr] <= din;
      dly_q       <= mem[rd_ptr];
    end
  end

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (rst)
    smp_en |=> wr_ptr == AW'($past(wr_ptr) + 1'b1));
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(wr_ptr) && $stable(odd_line));
  assert_parity_flip_R3: assert property (@(posedge clk) disable iff (rst)
    smp_en && line_start |=> odd_line != $past(odd_line));
endmodule

// File: rtl/yc_pipe_delay.sv
module yc_pipe_delay
  import yc_comb_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    en,
  input  sample_t din,
  output sample_t dout
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign dout = din;
    end else begin : g_regs
      sample_t stage [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
        end else if (en) begin
          stage[0] <= din;
          for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
        end
      end
      assign dout = stage[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/yc_comb_arith.sv
module yc_comb_arith
  import yc_comb_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    en,
  input  sample_t cur,
  input  sample_t dly,
  input  sample_t xcomp,
  output sample_t chroma_q,
  output sample_t luma_q
);
  sample_t chroma_a;
  sample_t x_a;
  wide_t   diff;
  wide_t   lsum;

  assign diff = wide_t'(cur) - wide_t'(dly);
  assign lsum = wide_t'(x_a) - wide_t'(chroma_a);

  always_ff @(posedge clk) begin
    if (rst) begin
      chroma_a <= '0;
      x_a      <= '0;
      chroma_q <= '0;
      luma_q   <= '0;
    end else if (en) begin
      chroma_a <= sat_w(diff >>> 1);
      x_a      <= xcomp;
      chroma_q <= chroma_a;
      luma_q   <= sat_w(lsum);
    end
  end

  assert_arith_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(chroma_q) && $stable(luma_q));
endmodule

// File: rtl/yc_comb_separator.sv
module yc_comb_separator
  import yc_comb_pkg::*;
#(
  parameter int LINE_SHORT = 682,
  parameter int BP_LAT     = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       smp_en,
  input  logic                       line_start,
  input  logic                       bypass,
  input  logic signed [SAMPLE_W-1:0] cvbs_in,
  input  logic signed [SAMPLE_W-1:0] ext_luma,
  input  logic signed [SAMPLE_W-1:0] ext_chroma,
  output logic signed [SAMPLE_W-1:0] luma_out,
  output logic signed [SAMPLE_W-1:0] chroma_out
);
  sample_t cur1, dly1, cur_bp, dly_bp, xcomp, comb_c, comb_y;

  yc_line_delay #(.LINE_SHORT(LINE_SHORT)) u_line (
    .clk(clk), .rst(rst), .smp_en(smp_en), .line_start(line_start),
    .din(cvbs_in), .cur_q(cur1), .dly_q(dly1));

  // band-pass placeholder: pure latency on both comb operands
  yc_pipe_delay #(.DEPTH(BP_LAT)) u_bp_cur (
    .clk(clk), .rst(rst), .en(smp_en), .din(cur1), .dout(cur_bp));
  yc_pipe_delay #(.DEPTH(BP_LAT)) u_bp_dly (
    .clk(clk), .rst(rst), .en(smp_en), .din(dly1), .dout(dly_bp));

  // compensation path matching the band-pass latency for the luma operand
  yc_pipe_delay #(.DEPTH(BP_LAT)) u_comp (
    .clk(clk), .rst(rst), .en(smp_en), .din(cur1), .dout(xcomp));

  yc_comb_arith u_arith (
    .clk(clk), .rst(rst), .en(smp_en), .cur(cur_bp), .dly(dly_bp),
    .xcomp(xcomp), .chroma_q(comb_c), .luma_q(comb_y));

  always_ff @(posedge clk) begin
    if (rst) begin
      luma_out   <= '0;
      chroma_out <= '0;
    end else if (smp_en) begin
      luma_out   <= bypass ? ext_luma   : comb_y;
      chroma_out <= bypass ? ext_chroma : comb_c;
    end
  end

  assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> luma_out == '0 && chroma_out == '0);
  assert_bypass_pass_R6: assert property (@(posedge clk) disable iff (rst)
    smp_en && bypass |=> luma_out == $past(ext_luma) && chroma_out == $past(ext_chroma));
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(luma_out) && $stable(chroma_out));
  assert_comb_select_R9: assert property (@(posedge clk) disable iff (rst)
    smp_en && !bypass |=> luma_out == $past(comb_y) && chroma_out == $past(comb_c));
endmodule

// File: tb/yc_comb_separator_bench.sv
module yc_comb_separator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SHORT_LEN  = 682;
  localparam int BP_LAT     = 2;
  localparam int OUT_LAT    = BP_LAT + 3;
  localparam int MAXS       = 8192;

  logic clk = 1'b0, rst = 1'b1, smp_en = 1'b0, line_start = 1'b0, bypass = 1'b0;
  logic signed [9:0] cvbs_in = '0, ext_luma = '0, ext_chroma = '0;
  logic signed [9:0] luma_out, chroma_out;

  yc_comb_separator #(.LINE_SHORT(SHORT_LEN), .BP_LAT(BP_LAT)) u_yc_comb_separator (
    .clk(clk), .rst(rst), .smp_en(smp_en), .line_start(line_start), .bypass(bypass),
    .cvbs_in(cvbs_in), .ext_luma(ext_luma), .ext_chroma(ext_chroma),
    .luma_out(luma_out), .chroma_out(chroma_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  int xs [MAXS];
  int dl [MAXS];
  int nsmp = 0;
  bit par = 1'b0;
  int n_tests = 0, n_fail = 0;
  int last_l = 0, last_c = 0;
  bit finished = 1'b0;

  function automatic int satv(int v);
    if (v > 511) return 511;
    if (v < -512) return -512;
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(int x, bit ls, bit byp, int ey, int ec, string tag);
    int m, s, y, c;
    @(negedge clk);
    smp_en = 1'b1; line_start = ls; bypass = byp;
    cvbs_in = 10'(x); ext_luma = 10'(ey); ext_chroma = 10'(ec);
    xs[nsmp] = x;
    dl[nsmp] = (par ^ ls) ? SHORT_LEN + 1 : SHORT_LEN;
    if (ls) par = ~par;
    m = nsmp;
    nsmp++;
    @(posedge clk);
    #1;
    if (byp) begin
      check({tag, " bypass luma"}, int'(luma_out), ey);
      check({tag, " bypass chroma"}, int'(chroma_out), ec);
    end else begin
      s = m - OUT_LAT;
      if (s >= 0 && s - dl[s] >= 0) begin
        y = xs[s - dl[s]];
        c = satv((xs[s] - y) >>> 1);
        check({tag, " chroma"}, int'(chroma_out), c);
        check({tag, " luma"}, int'(luma_out), satv(xs[s] - c));
      end
    end
    last_l = int'(luma_out);
    last_c = int'(chroma_out);
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    smp_en = 1'b0; line_start = 1'b1; bypass = ~bypass;
    cvbs_in = 10'sd300; ext_luma = -10'sd77; ext_chroma = 10'sd123;
    @(posedge clk);
    #1;
    check({tag, " hold luma"}, int'(luma_out), last_l);
    check({tag, " hold chroma"}, int'(chroma_out), last_c);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    last_l = 0; last_c = 0;
    for (int i = 0; i < 3; i++) idle("R1");
  endtask

  task automatic t_fill;
    for (int i = 0; i < 1400; i++)
      push(((i * 37 + 11) % 1024) - 512, (i == 0 || i == 683 || i == 1365), 1'b0, 0, 0,
           "R2/R3/R4/R5/R7");
  endtask

  task automatic t_parity;
    for (int i = 0; i < 40; i++)
      push(((i * 91) % 1000) - 500, (i % 5 == 0), 1'b0, 0, 0, "R2/R3");
  endtask

  task automatic t_extremes;
    int x;
    for (int i = 0; i < 700; i++) begin
      case (i % 4)
        0: x = 511;
        1: x = -512;
        2: x = (i % 8 == 2) ? 1 : 0;
        default: x = -1;
      endcase
      push(x, 1'b0, 1'b0, 0, 0, "R4/R5");
    end
  endtask

  task automatic t_bypass;
    for (int i = 0; i < 40; i++)
      push((i * 23) % 400 - 200, 1'b0, ((i / 3) % 2) == 1, i * 13 - 200, 100 - i * 7, "R6/R9");
  endtask

  task automatic t_stall;
    for (int i = 0; i < 30; i++) begin
      push((i * 59) % 900 - 450, (i == 12), (i % 7 == 3), 5 * i, -3 * i, "R8/R7");
      idle("R8");
    end
  endtask

  initial begin
    t_reset();
    t_fill();
    t_parity();
    t_extremes();
    t_bypass();
    t_stall();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule